// File: doc/BRIEF.md
# Embedded Erase Sequencer

This block carries out an automatic erase once the command decoder hands it a start. A whole-array start targets every sector that is not write-protected. A sector start targets the sectors set in a request mask, again minus the protected ones. The host gives no further control. The sequencer visits the target sectors one at a time, lowest index first. In each sector it first writes every word to zero and reads each one back. It then erases the sector and reads every word back as all ones. A failed read-back repeats the operation it was checking.

Each array micro-operation goes to the storage array through a request/acknowledge pair. The sequencer also drives the bank's busy indication and three status bits:

- a completion bit,
- a toggle that flips on every status read while busy,
- a second toggle that flips only when the read addresses a sector being erased.

Writes that arrive while it is busy are ignored. A synchronous hardware reset abandons the erase on the next edge and leaves the array partly processed.

Top module: `erase_seq`

## Requirements
- R1: With `rst` high at an edge, the next cycle shows `ready`=1, `dq7`=1, `dq6`=0, `dq2`=0 and `op_req`=0. This includes a reset in the middle of an erase. No further operation is requested and the array is left partly processed.
- R2: Whole-array start (`start_chip`) targets every sector whose `prot_mask` bit is 0. Sector start (`start_sect`) targets `sect_mask & ~prot_mask`. Targets are served in ascending index order, and a protected sector never appears on `op_sect`.
- R3: For each target sector s, the operations run in this order. First, for each word w = 0..WPS-1: program (`op_kind`=0) of word w, then verify-zero (`op_kind`=1) of word w. Then one sector erase (`op_kind`=2, `op_word`=0). Then verify-ones (`op_kind`=3) for each word w = 0..WPS-1.
- R4: A verify-zero acknowledged with `op_ok`=0 repeats program and verify-zero of the same word. A verify-ones acknowledged with `op_ok`=0 repeats the sector erase and then resumes verify-ones at the same word.
- R5: Once `op_req` is high it stays high, with `op_kind`, `op_sect` and `op_word` unchanged, until a cycle with `op_ack`=1. The cycle after that acknowledge shows `op_req`=0.
- R6: `ready` falls on the edge that accepts a start and rises one cycle after the final verify-ones acknowledge. `dq7` equals `ready` at all times. `op_req` is never high while `ready` is high.
- R7: If the target set is empty, `ready` stays low for exactly HOLD_CYC cycles. No operation is requested and no array data changes.
- R8: Every `rd_stb` sampled while busy flips `dq6` on that edge. While ready, `dq6` holds.
- R9: `rd_stb` sampled while busy flips `dq2` only if the `rd_sect` bit is set in the target set. Completion clears the latched target set.
- R10: `start_chip` and `start_sect` sampled while busy have no effect on the sequence of operations or on which sectors are erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset, aborts an erase |
| start_chip | input | 1 | Whole-array erase start pulse |
| start_sect | input | 1 | Sector erase start pulse |
| sect_mask | input | NSEC | Sectors requested by a sector start |
| prot_mask | input | NSEC | Write-protected sectors |
| rd_stb | input | 1 | Status read strobe |
| rd_sect | input | SW | Sector addressed by the status read |
| op_req | output | 1 | Array operation request |
| op_kind | output | 2 | 0 program-zero, 1 verify-zero, 2 erase sector, 3 verify-ones |
| op_sect | output | SW | Sector of the operation |
| op_word | output | WW | Word of the operation |
| op_ack | input | 1 | Array acknowledge, one cycle |
| op_ok | input | 1 | Verify result, valid with `op_ack` |
| ready | output | 1 | 1 in read mode, 0 while erasing |
| dq7 | output | 1 | Completion bit: 0 busy, 1 done |
| dq6 | output | 1 | Toggle on every status read while busy |
| dq2 | output | 1 | Toggle on status reads of target sectors while busy |

## Verification
The properties assume that the array raises `op_ack` for one cycle, and only while `op_req` is high. They also assume that `prot_mask` does not change while an erase runs, since the protection check compares the current sector against the live mask. The bench's array model acknowledges only a pending request and drops the acknowledge on the next cycle. The stimulus changes `sect_mask` and `prot_mask` only while `ready` is high. Verify failures are injected through the model's `op_ok` answer, never through a spurious acknowledge.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_VFY0  = 2'd1,
    OP_ERASE = 2'd2,
    OP_VFY1  = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_PICK, ST_PROG, ST_PVFY, ST_ERASE, ST_EVFY
  } seq_st_t;
endpackage

// File: rtl/es_pick.sv
// Lowest-index pending sector finder.
module es_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] pend,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/es_status.sv
// Toggle status bits flipped by status reads during an erase.
module es_status #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         busy,
  input  logic         rd_stb,
  input  logic [W-1:0] rd_sect,
  input  logic [N-1:0] tgt,
  output logic         tog_all,
  output logic         tog_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tog_all <= 1'b0;
      tog_sel <= 1'b0;
    end else if (rd_stb && busy) begin
      tog_all <= ~tog_all;
      if (tgt[rd_sect]) tog_sel <= ~tog_sel;
    end
  end
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int NSEC     = 8,
  parameter int WPS      = 4,
  parameter int HOLD_CYC = 4,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int WW = (WPS > 1) ? $clog2(WPS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_chip,
  input  logic            start_sect,
  input  logic [NSEC-1:0] sect_mask,
  input  logic [NSEC-1:0] prot_mask,
  input  logic            rd_stb,
  input  logic [SW-1:0]   rd_sect,
  output logic            op_req,
  output logic [1:0]      op_kind,
  output logic [SW-1:0]   op_sect,
  output logic [WW-1:0]   op_word,
  input  logic            op_ack,
  input  logic            op_ok,
  output logic            ready,
  output logic            dq7,
  output logic            dq6,
  output logic            dq2
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  seq_st_t         st;
  logic [NSEC-1:0] rem, tgt;
  logic [SW-1:0]   cur;
  logic [WW-1:0]   wd;
  logic [HW-1:0]   hcnt;
  logic            req_q, busy_q;
  logic            pick_any;
  logic [SW-1:0]   pick_idx;
  logic [NSEC-1:0] new_set;
  logic            go, acked, last_wd, in_op;
  op_kind_t        kind;

  es_pick #(.N(NSEC), .W(SW)) u_pick (
    .pend(rem), .any(pick_any), .idx(pick_idx)
  );

  es_status #(.N(NSEC), .W(SW)) u_stat (
    .clk(clk), .rst(rst), .busy(busy_q), .rd_stb(rd_stb),
    .rd_sect(rd_sect), .tgt(tgt), .tog_all(dq6), .tog_sel(dq2)
  );

  assign new_set = start_chip ? ~prot_mask : (sect_mask & ~prot_mask);
  assign go      = start_chip | start_sect;
  assign acked   = req_q & op_ack;
  assign last_wd = (wd == WW'(WPS - 1));
  assign in_op   = (st == ST_PROG) || (st == ST_PVFY) ||
                   (st == ST_ERASE) || (st == ST_EVFY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      rem    <= '0;
      tgt    <= '0;
      cur    <= '0;
      wd     <= '0;
      hcnt   <= '0;
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (in_op && !req_q) req_q <= 1'b1;
      case (st)
        ST_IDLE: if (go) begin
          busy_q <= 1'b1;
          rem    <= new_set;
          tgt    <= new_set;
          if (|new_set) st <= ST_PICK;
          else begin
            st   <= ST_HOLD;
            hcnt <= HW'(HOLD_CYC - 1);
          end
        end
        ST_HOLD: if (hcnt == '0) begin
          busy_q <= 1'b0;
          st     <= ST_IDLE;
        end else hcnt <= hcnt - 1'b1;
        ST_PICK: if (pick_any) begin
          cur <= pick_idx;
          wd  <= '0;
          st  <= ST_PROG;
        end else begin
          busy_q <= 1'b0;
          tgt    <= '0;
          st     <= ST_IDLE;
        end
        ST_PROG: if (acked) begin
          req_q <= 1'b0;
          st    <= ST_PVFY;
        end
        ST_PVFY: if (acked) begin
          req_q <= 1'b0;
          if (!op_ok) st <= ST_PROG;
          else if (last_wd) begin
            wd <= '0;
            st <= ST_ERASE;
          end else begin
            wd <= wd + 1'b1;
            st <= ST_PROG;
          end
        end
        ST_ERASE: if (acked) begin
          req_q <= 1'b0;
          st    <= ST_EVFY;
        end
        ST_EVFY: if (acked) begin
          req_q <= 1'b0;
          if (!op_ok) st <= ST_ERASE;
          else if (last_wd) begin
            wd       <= '0;
            rem[cur] <= 1'b0;
            st       <= ST_PICK;
          end else wd <= wd + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_PVFY:  kind = OP_VFY0;
      ST_ERASE: kind = OP_ERASE;
      ST_EVFY:  kind = OP_VFY1;
      default:  kind = OP_PROG;
    endcase
  end

  assign op_req  = req_q;
  assign op_kind = kind;
  assign op_sect = cur;
  assign op_word = (st == ST_ERASE) ? '0 : wd;
  assign ready   = ~busy_q;
  assign dq7     = ~busy_q;
endmodule

// File: rtl/es_chk.sv
module es_chk #(
  parameter int NSEC = 8,
  parameter int SW   = 3,
  parameter int WW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NSEC-1:0] prot_mask,
  input logic            rd_stb,
  input logic            op_req,
  input logic [1:0]      op_kind,
  input logic [SW-1:0]   op_sect,
  input logic [WW-1:0]   op_word,
  input logic            op_ack,
  input logic            ready,
  input logic            dq6,
  input logic            dq2
);
  AST_RST_ABORT: assert property (@(posedge clk)
    rst |=> (ready && !op_req && !dq6 && !dq2)); // R1
  AST_PROT_SKIP: assert property (@(posedge clk) disable iff (rst)
    op_req |-> !prot_mask[op_sect]); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_req && !op_ack) |=> (op_req && $stable(op_kind) && $stable(op_sect) && $stable(op_word))); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (op_req && op_ack) |=> !op_req); // R5
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
    op_req |-> !ready); // R6
  AST_DQ6_TOG: assert property (@(posedge clk) disable iff (rst)
    (!ready && rd_stb) |=> (dq6 != $past(dq6))); // R8
  AST_DQ6_IDLE: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(dq6)); // R8
endmodule

bind erase_seq es_chk #(.NSEC(NSEC), .SW(SW), .WW(WW)) u_chk (
  .clk(clk), .rst(rst), .prot_mask(prot_mask), .rd_stb(rd_stb),
  .op_req(op_req), .op_kind(op_kind), .op_sect(op_sect), .op_word(op_word),
  .op_ack(op_ack), .ready(ready), .dq6(dq6), .dq2(dq2)
);

// File: tb/sim_erase_seq.sv
`timescale 1ns/1ps
module sim_erase_seq;
  localparam int NSEC = 8, WPS = 4, HOLD_CYC = 4, LAT = 2;
  localparam int SW = 3, WW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_chip = 1'b0, start_sect = 1'b0;
  logic [NSEC-1:0] sect_mask = '0, prot_mask = '0;
  logic rd_stb = 1'b0;
  logic [SW-1:0] rd_sect = '0;
  logic op_req, op_ack = 1'b0, op_ok = 1'b0;
  logic [1:0] op_kind;
  logic [SW-1:0] op_sect;
  logic [WW-1:0] op_word;
  logic ready, dq7, dq6, dq2;

  always #2.5 clk = ~clk;

  erase_seq #(.NSEC(NSEC), .WPS(WPS), .HOLD_CYC(HOLD_CYC)) u0 (
    .clk(clk), .rst(rst), .start_chip(start_chip), .start_sect(start_sect),
    .sect_mask(sect_mask), .prot_mask(prot_mask), .rd_stb(rd_stb), .rd_sect(rd_sect),
    .op_req(op_req), .op_kind(op_kind), .op_sect(op_sect), .op_word(op_word),
    .op_ack(op_ack), .op_ok(op_ok), .ready(ready), .dq7(dq7), .dq6(dq6), .dq2(dq2)
  );

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural array model ----------------
  logic [7:0] mem [NSEC*WPS];
  bit mem_init = 0;
  int acnt = 0;
  int inj_pv_req = 0, inj_pv_done = 0, inj_ev_req = 0, inj_ev_done = 0;

  always @(negedge clk) begin
    if (!mem_init) begin
      foreach (mem[i]) mem[i] = 8'hA5;
      mem_init = 1;
    end
    if (rst) begin
      op_ack = 1'b0;
      acnt = 0;
    end else if (op_ack) begin
      op_ack = 1'b0;
    end else if (op_req) begin
      acnt++;
      if (acnt >= LAT) begin
        int a;
        acnt = 0;
        op_ack = 1'b1;
        a = int'(op_sect) * WPS + int'(op_word);
        case (op_kind)
          2'd0: begin mem[a] = 8'h00; op_ok = 1'b1; end
          2'd1: begin
            op_ok = (mem[a] == 8'h00);
            if (inj_pv_req > inj_pv_done) begin op_ok = 1'b0; inj_pv_done++; end
          end
          2'd2: begin
            for (int w = 0; w < WPS; w++) mem[int'(op_sect)*WPS + w] = 8'hFF;
            op_ok = 1'b1;
          end
          default: begin
            op_ok = (mem[a] == 8'hFF);
            if (inj_ev_req > inj_ev_done) begin op_ok = 1'b0; inj_ev_done++; end
          end
        endcase
      end
    end else acnt = 0;
  end

  // ---------------- status read generator ----------------
  int rd_cnt = 0;
  always @(negedge clk) begin
    rd_cnt++;
    rd_stb = (rd_cnt % 3 == 0);
    rd_sect = SW'((rd_cnt / 3) % NSEC);
  end

  // ---------------- cycle reference model ----------------
  int q[$];
  bit m_busy = 0, m_drop = 0, ob, p_valid = 0;
  int m_hold = 0;
  logic m_dq6 = 0, m_dq2 = 0;
  logic [NSEC-1:0] m_tgt = '0;
  logic p_rst, p_go, p_chip, p_rd, p_req, p_ack, p_ok;
  logic [NSEC-1:0] p_mask, p_prot;
  logic [SW-1:0] p_rds, p_sect;
  logic [1:0] p_kind;
  logic [WW-1:0] p_word;

  function automatic int code(input int k, input int s, input int w);
    return (k << 16) | (s << 8) | w;
  endfunction

  task automatic build(input logic [NSEC-1:0] t);
    for (int s = 0; s < NSEC; s++) if (t[s]) begin
      for (int w = 0; w < WPS; w++) begin
        q.push_back(code(0, s, w));
        q.push_back(code(1, s, w));
      end
      q.push_back(code(2, s, 0));
      for (int w = 0; w < WPS; w++) q.push_back(code(3, s, w));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    #1;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      summary();
      $finish;
    end
    if (p_valid) begin
      ob = m_busy;
      if (p_rst) begin
        m_busy = 0; m_drop = 0; m_hold = 0; m_dq6 = 0; m_dq2 = 0; m_tgt = '0;
        q.delete();
      end else begin
        if (p_rd && ob) begin
          m_dq6 = ~m_dq6;
          if (m_tgt[p_rds]) m_dq2 = ~m_dq2;
        end
        if (m_drop) begin
          m_busy = 0; m_drop = 0; m_tgt = '0;
        end else if (m_hold > 0) begin
          m_hold--;
          if (m_hold == 0) m_busy = 0;
        end
        if (p_req && p_ack) begin
          int got, exp;
          got = code(int'(p_kind), int'(p_sect), int'(p_word));
          if (q.size() == 0) chk("R3 unexpected operation", got, -1);
          else begin
            exp = q.pop_front();
            chk("R3 operation order (R2 sector choice)", got, exp);
            if (!p_ok && p_kind == 2'd1) begin
              q.push_front(code(1, int'(p_sect), int'(p_word)));
              q.push_front(code(0, int'(p_sect), int'(p_word)));
            end
            if (!p_ok && p_kind == 2'd3) begin
              q.push_front(code(3, int'(p_sect), int'(p_word)));
              q.push_front(code(2, int'(p_sect), 0));
            end
            if (q.size() == 0 && m_busy) m_drop = 1;
          end
        end
        if (!ob && p_go) begin
          logic [NSEC-1:0] t;
          t = p_chip ? ~p_prot : (p_mask & ~p_prot);
          m_busy = 1;
          m_tgt = t;
          if (t == '0) m_hold = HOLD_CYC;
          else build(t);
        end
        if (p_req && !p_ack) begin
          chk("R5 request held", int'(op_req), 1);
          chk("R5 fields stable", int'({op_kind, op_sect, op_word}),
              int'({p_kind, p_sect, p_word}));
        end
        if (p_req && p_ack) chk("R5 request dropped after ack", int'(op_req), 0);
      end
      chk("R6 ready", int'(ready), int'(!m_busy));
      chk("R6 dq7", int'(dq7), int'(!m_busy));
      chk("R8 dq6", int'(dq6), int'(m_dq6));
      chk("R9 dq2", int'(dq2), int'(m_dq2));
      if (!m_busy) chk("R6 no request while ready", int'(op_req), 0);
    end
    p_rst = rst; p_go = start_chip | start_sect; p_chip = start_chip;
    p_mask = sect_mask; p_prot = prot_mask; p_rd = rd_stb; p_rds = rd_sect;
    p_req = op_req; p_ack = op_ack; p_ok = op_ok;
    p_kind = op_kind; p_sect = op_sect; p_word = op_word;
    p_valid = 1;
  end

  // ---------------- stimulus ----------------
  task automatic start(input bit chip, input logic [NSEC-1:0] m, input logic [NSEC-1:0] p);
    @(negedge clk);
    sect_mask = m; prot_mask = p;
    start_chip = chip; start_sect = !chip;
    @(negedge clk);
    start_chip = 0; start_sect = 0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int mw(input int s, input int w);
    return int'(mem[s*WPS + w]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    chk("R1 ready after reset", int'(ready), 1);
    chk("R1 dq7 after reset", int'(dq7), 1);
    chk("R1 no request after reset", int'(op_req), 0);

    // T1: sector erase of sectors 0 and 2
    start(0, 8'h05, 8'h00);
    wait_ready();
    chk("R2 sector 0 erased", mw(0, 3), 8'hFF);
    chk("R2 sector 2 erased", mw(2, 0), 8'hFF);
    chk("R2 sector 1 untouched", mw(1, 0), 8'hA5);

    // T2: start while busy ignored
    start(0, 8'h08, 8'h00);
    repeat (10) @(negedge clk);
    @(negedge clk); start_chip = 1;
    @(negedge clk); start_chip = 0;
    wait_ready();
    chk("R10 sector 3 erased", mw(3, 2), 8'hFF);
    chk("R10 sector 1 untouched by ignored start", mw(1, 1), 8'hA5);
    chk("R10 sector 4 untouched by ignored start", mw(4, 1), 8'hA5);

    // T3: every selected sector protected
    begin
      int n;
      start(0, 8'h10, 8'h10);
      n = 1;
      while (!ready && n < 100) begin
        @(negedge clk);
        if (!ready) n++;
      end
      chk("R7 busy length with empty target set", n, HOLD_CYC);
      repeat (3) @(negedge clk);
      chk("R7 protected sector data unchanged", mw(4, 0), 8'hA5);
    end

    // T4: verify failures trigger retries
    inj_pv_req++;
    inj_ev_req++;
    start(0, 8'h40, 8'h00);
    wait_ready();
    chk("R4 sector 6 erased after retries", mw(6, 3), 8'hFF);
    chk("R4 both injected failures consumed", inj_pv_done + inj_ev_done, 2);

    // T5: whole-array erase with protection
    start(1, 8'h00, 8'h12);
    wait_ready();
    chk("R2 protected sector 1 kept", mw(1, 2), 8'hA5);
    chk("R2 protected sector 4 kept", mw(4, 3), 8'hA5);
    chk("R2 sector 5 erased", mw(5, 0), 8'hFF);
    chk("R2 sector 7 erased", mw(7, 3), 8'hFF);

    // T6: hardware reset aborts mid-operation
    start(1, 8'h00, 8'h00);
    repeat (20) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #2;
    chk("R1 ready right after abort", int'(ready), 1);
    chk("R1 request gone after abort", int'(op_req), 0);
    repeat (20) @(negedge clk);
    chk("R1 abort leaves work started", mw(0, 0), 8'h00);
    chk("R1 abort leaves work unfinished", mw(0, 3), 8'hFF);
    chk("R1 no request after abort", int'(op_req), 0);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule